// File: doc/BRIEF.md
# Status Flag Interrupt Register

This block keeps eight condition flags for a processor, each paired with its own interrupt-enable bit, and a 3-bit interrupt channel number. Hardware event lines raise flags directly. Software changes the block through a single control-word write. One write can carry any mix of four commands: enable, disable, clear and set. These commands act only on the flags picked by an 8-bit select mask in the same word. Every write also loads the channel number.

A read word returns the current flags, the channel and a summary bit that shows whether the unit is asking for service. The block drives a 7-bit one-hot request vector toward a priority interrupt controller. The bit for level N is raised while the channel holds N and at least one flag is both set and enabled. Channel 0 disables the request.

Top module: `sfi_status_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, all flags, all enables and the channel are zero, so rd_data reads 0 and irq_req is 0.
- R2: Control word layout: bit 15 = enable command, bit 14 = disable command, bit 13 = clear command, bit 12 = set command, bits 11:4 = flag select (flag k at bit 4+k), bits 2:0 = channel. Bits 17, 16 and 3 are ignored. Every write with wr_en high loads the channel from bits 2:0.
- R3: A clear command zeroes the selected flags on the write edge and leaves unselected flags unchanged.
- R4: A set command raises the selected flags. When set and clear arrive in one write, the selected flags end up set.
- R5: An enable command turns on the interrupt enable of the selected flags and a disable command turns it off. When both arrive in one write, the selected enables end up on.
- R6: hw_evt[k] high at a clock edge sets flag k on that edge. It wins over a clear command that hits the same flag in the same cycle.
- R7: rd_data holds the flags in bits 11:4 (flag k at bit 4+k), the request summary in bit 3 and the channel in bits 2:0. All other bits are 0.
- R8: The request summary is 1 exactly when some flag is both set and enabled and the channel is nonzero.
- R9: irq_req bit N-1 is 1 exactly when the request summary is 1 and the channel equals N. irq_req never has more than one bit set.
- R10: A write that carries no command bits changes no flag and no enable. Only the channel is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 18 | Control word |
| hw_evt | input | 8 | Hardware event lines, one per flag |
| rd_data | output | 18 | Status read word |
| irq_req | output | 7 | One-hot request, bit N-1 for level N |

## Verification
A flag or enable bit stuck in the wrong state shows up in rd_data bits 11:4 or in the request summary one clock after the write or event that should have changed it. A wrong channel register moves the request to the wrong bit of irq_req on the same cycle. The tests therefore mix command bits within single writes and put events against clears. Each write is then followed by a read of the whole status word and of irq_req one cycle later. The priority rules for clear against set, disable against enable, and event against clear are therefore visible at the ports straight away.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int NFLAG = 8;
  localparam int CHW   = 3;
  localparam int WORDW = 18;
  localparam int NLVL  = (1 << CHW) - 1;

  localparam int BIT_ENA  = 15;
  localparam int BIT_DIS  = 14;
  localparam int BIT_CLR  = 13;
  localparam int BIT_SET  = 12;
  localparam int SEL_LSB  = 4;
  localparam int SEL_MSB  = SEL_LSB + NFLAG - 1;
  localparam int BIT_REQ  = 3;

  typedef struct packed {
    logic             wr;
    logic             ena;
    logic             dis;
    logic             clr;
    logic             set;
    logic [NFLAG-1:0] sel;
    logic [CHW-1:0]   chan;
  } sfi_cmd_t;
endpackage

// File: rtl/sfi_cmd_decode.sv
module sfi_cmd_decode
  import sfi_pkg::*;
(
  input  logic             wr_en,
  input  logic [WORDW-1:0] wr_data,
  output sfi_cmd_t         cmd
);
  always_comb begin
    cmd.wr   = wr_en;
    cmd.ena  = wr_en & wr_data[BIT_ENA];
    cmd.dis  = wr_en & wr_data[BIT_DIS];
    cmd.clr  = wr_en & wr_data[BIT_CLR];
    cmd.set  = wr_en & wr_data[BIT_SET];
    cmd.sel  = wr_data[SEL_MSB:SEL_LSB];
    cmd.chan = wr_data[CHW-1:0];
  end
endmodule

// File: rtl/sfi_flag_bank.sv
module sfi_flag_bank
  import sfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sfi_cmd_t         cmd,
  input  logic [NFLAG-1:0] hw_evt,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] en_q
);
  logic [NFLAG-1:0] flag_d, en_d, flag_ce, en_ce;

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    logic hit;
    assign hit = cmd.sel[k];

    always_comb begin
      flag_ce[k] = hw_evt[k] | (hit & (cmd.clr | cmd.set));
      flag_d[k]  = hw_evt[k] | (hit & cmd.set) | (flag_q[k] & ~(hit & cmd.clr));
      en_ce[k]   = hit & (cmd.ena | cmd.dis);
      en_d[k]    = (hit & cmd.ena) | (en_q[k] & ~(hit & cmd.dis));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
        en_q[k]   <= 1'b0;
      end else begin
        if (flag_ce[k]) flag_q[k] <= flag_d[k];
        if (en_ce[k])   en_q[k]   <= en_d[k];
      end
    end
  end

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.set |=> ((flag_q & $past(cmd.sel)) == $past(cmd.sel)));
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !cmd.set) |=> ((flag_q & $past(cmd.sel & ~hw_evt)) == '0));
  a_r5_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.dis && !cmd.ena) |=> ((en_q & $past(cmd.sel)) == '0));
  a_r5_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.ena |=> ((en_q & $past(cmd.sel)) == $past(cmd.sel)));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clr && !cmd.set && hw_evt == '0) |=> $stable(flag_q));
endmodule

// File: rtl/sfi_irq_encode.sv
module sfi_irq_encode
  import sfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sfi_cmd_t         cmd,
  input  logic [NFLAG-1:0] flag_q,
  input  logic [NFLAG-1:0] en_q,
  output logic [CHW-1:0]   chan_q,
  output logic             req,
  output logic [NLVL-1:0]  irq_req
);
  logic [CHW-1:0] chan_d;

  always_comb chan_d = cmd.chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chan_q <= '0;
    else if (cmd.wr) chan_q <= chan_d;
  end

  always_comb req = (|(flag_q & en_q)) & (chan_q != '0);

  for (genvar lv = 1; lv <= NLVL; lv++) begin : g_lvl
    assign irq_req[lv-1] = req & (chan_q == CHW'(lv));
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req));
  a_r8_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_q == '0) |-> (irq_req == '0));
  a_r2_chan_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wr |=> (chan_q == $past(cmd.chan)));
endmodule

// File: rtl/sfi_status_unit.sv
module sfi_status_unit
  import sfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WORDW-1:0] wr_data,
  input  logic [NFLAG-1:0] hw_evt,
  output logic [WORDW-1:0] rd_data,
  output logic [NLVL-1:0]  irq_req
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  sfi_cmd_t         cmd;
  logic [NFLAG-1:0] flag_q, en_q;
  logic [CHW-1:0]   chan_q;
  logic             req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sfi_cmd_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  sfi_flag_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cmd    (cmd),
    .hw_evt (hw_evt),
    .flag_q (flag_q),
    .en_q   (en_q)
  );

  sfi_irq_encode u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cmd     (cmd),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .chan_q  (chan_q),
    .req     (req),
    .irq_req (irq_req)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[SEL_MSB:SEL_LSB] = flag_q;
    rd_data[BIT_REQ]         = req;
    rd_data[CHW-1:0]         = chan_q;
  end

  a_r7_req_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[BIT_REQ] == (irq_req != '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (irq_req == '0));
endmodule

// File: tb/sfi_status_unit_tb.sv
module sfi_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [17:0] wr_data;
  logic [7:0]  hw_evt;
  logic [17:0] rd_data;
  logic [6:0]  irq_req;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sfi_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_evt(hw_evt), .rd_data(rd_data), .irq_req(irq_req)
  );

  // entry: wr(1) wdata(18) evt(8) exp_rd(18) exp_irq(7)
  // wdata = {2'b00, ena, dis, clr, set, sel[7:0], 1'b0, ch[2:0]}
  // exp_rd = {6'b0, flags[7:0], req, ch[2:0]}
  localparam int NV = 13;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 2'b00,4'b0001,8'h05,1'b0,3'd3, 8'h00, 6'd0,8'h05,1'b0,3'd3, 7'b0000000}, // R4 set
    {1'b1, 2'b00,4'b1000,8'h04,1'b0,3'd3, 8'h00, 6'd0,8'h05,1'b1,3'd3, 7'b0000100}, // R5 R9 enable
    {1'b1, 2'b00,4'b0010,8'h04,1'b0,3'd3, 8'h00, 6'd0,8'h01,1'b0,3'd3, 7'b0000000}, // R3 clear
    {1'b0, 2'b00,4'b0000,8'h00,1'b0,3'd0, 8'h10, 6'd0,8'h11,1'b0,3'd3, 7'b0000000}, // R6 event
    {1'b1, 2'b00,4'b1000,8'h10,1'b0,3'd7, 8'h00, 6'd0,8'h11,1'b1,3'd7, 7'b1000000}, // R8 R9 level 7
    {1'b1, 2'b00,4'b0011,8'h10,1'b0,3'd7, 8'h00, 6'd0,8'h11,1'b1,3'd7, 7'b1000000}, // R4 set beats clear
    {1'b1, 2'b00,4'b0010,8'h10,1'b0,3'd7, 8'h10, 6'd0,8'h11,1'b1,3'd7, 7'b1000000}, // R6 event beats clear
    {1'b1, 2'b00,4'b0000,8'hFF,1'b0,3'd0, 8'h00, 6'd0,8'h11,1'b0,3'd0, 7'b0000000}, // R10 R8 channel 0
    {1'b1, 2'b00,4'b1100,8'h01,1'b0,3'd1, 8'h00, 6'd0,8'h11,1'b1,3'd1, 7'b0000001}, // R5 enable beats disable
    {1'b1, 2'b00,4'b0100,8'h11,1'b0,3'd1, 8'h00, 6'd0,8'h11,1'b0,3'd1, 7'b0000000}, // R5 disable
    {1'b1, 2'b00,4'b0010,8'hFF,1'b0,3'd1, 8'h00, 6'd0,8'h00,1'b0,3'd1, 7'b0000000}, // R3 clear all
    {1'b1, 2'b00,4'b1001,8'h80,1'b0,3'd5, 8'h00, 6'd0,8'h80,1'b1,3'd5, 7'b0010000}, // R4 R5 set+enable
    {1'b1, 2'b11,4'b0000,8'h00,1'b1,3'd2, 8'h00, 6'd0,8'h80,1'b1,3'd2, 7'b0000010}  // R2 R7 spare bits ignored
  };

  task automatic check(input string req, input logic [17:0] er, input logic [6:0] ei);
    checks++;
    if (rd_data !== er || irq_req !== ei) begin
      errors++;
      $display("FAIL %s rd=%o irq=%b expected rd=%o irq=%b", req, rd_data, irq_req, er, ei);
    end
  endtask

  task automatic drive(input logic w, input logic [17:0] d, input logic [7:0] e);
    @(negedge clk);
    wr_en = w; wr_data = d; hw_evt = e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; hw_evt = '0;
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; hw_evt = '0;
    #1;
    check("R1 in reset", 18'o0, 7'b0);
    repeat (3) @(negedge clk);
    check("R1 during reset", 18'o0, 7'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 18'o0, 7'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51], VEC[i][50:33], VEC[i][32:25]);
      check($sformatf("vector %0d R2 R3 R4 R5 R6 R7 R8 R9 R10", i), VEC[i][24:7], VEC[i][6:0]);
    end

    // R1: asynchronous reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 18'o0, 7'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: enable was cleared by reset, so setting the flag raises no request
    drive(1'b1, {2'b00,4'b0001,8'h80,1'b0,3'd5}, 8'h00);
    check("R1 enables cleared", {6'd0,8'h80,1'b0,3'd5}, 7'b0);
    drive(1'b1, {2'b00,4'b1000,8'h80,1'b0,3'd5}, 8'h00);
    check("R8 R9 re-enable", {6'd0,8'h80,1'b1,3'd5}, 7'b0010000);
    // R6: events on all lines with no write
    drive(1'b0, 18'o0, 8'hFF);
    check("R6 all events", {6'd0,8'hFF,1'b1,3'd5}, 7'b0010000);
    // R10: idle cycle keeps state
    drive(1'b0, 18'o0, 8'h00);
    check("R10 idle hold", {6'd0,8'hFF,1'b1,3'd5}, 7'b0010000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule